// File: doc/BRIEF.md
# Prioritized Interrupt Level Resolver

This block merges two sources of interrupt requests into one decision: a software request word and a word of external request lines. Each pending request maps to a priority level. The highest pending level is compared against the processor's current interrupt priority level. When the pending level is strictly higher, the block issues a one-cycle trap request. On the same clock edge it stores two things: a summary word holding every pending request bit at its own position, and the winning level as the interrupt identifier.

Software requests use a field of the request word starting at `SW_LO`, and the lowest software bit maps to level 1. External lines use the field from `EXT_LO` to `EXT_HI`, and each line's level equals its bit index, so any external request outranks every software request. A separate asynchronous trap request input is not serviced. When it is nonzero, an unsupported flag is raised and interrupt delivery is held off.

Top module: `irq_level_resolver`

## Requirements
- R1: A software request at bit i (4 to 18) resolves to level i−3, so bit 4 gives level 1 and bit 18 gives level 15. When several software bits are set, the highest one wins.
- R2: An external request at bit i (20 to 30) resolves to level i. When several external bits are set, the highest one wins.
- R3: If any external bit is pending, the resolved level is the external level, whatever software bits are set.
- R4: The summary is the OR, bit by bit, of the pending software bits (positions 4 to 18) and the pending external bits (positions 20 to 30). Request bits outside those fields are ignored and never appear in the summary or affect the level.
- R5: A trap is taken only when the resolved level is nonzero and strictly greater than `cur_ipl_i`. An equal or lower level gives no trap.
- R6: `trap_o` goes high for exactly one cycle. It rises in the cycle after the inputs first satisfy R5, then stays low while those inputs keep satisfying R5. It fires again only after the condition has been false for at least one cycle.
- R7: `summary_o` and `int_id_o` load the summary and the level on the same edge that raises `trap_o`. At every other edge they hold their values.
- R8: A nonzero `ast_req_i` sets `unsup_o` on the next cycle and blocks any trap for that cycle. `unsup_o` follows `ast_req_i` with one cycle of latency.
- R9: After reset, `trap_o`, `unsup_o`, `summary_o` and `int_id_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_req_i | input | 32 | Software request word; only bits 4 to 18 are used |
| ext_req_i | input | 32 | External request lines; only bits 20 to 30 are used |
| cur_ipl_i | input | 5 | Current interrupt priority level |
| ast_req_i | input | 4 | Asynchronous trap request (unsupported) |
| trap_o | output | 1 | One-cycle trap request pulse |
| summary_o | output | 32 | Summary of pending requests, captured at the trap |
| int_id_o | output | 5 | Winning level, captured at the trap |
| unsup_o | output | 1 | Unsupported asynchronous trap request seen |

## Verification
Two of the block's functions can act in the same cycle. First, software and external arbitration: the bench sets a top software bit together with the lowest external line, and with several bits in each field. It then expects the external level in `int_id_o` and both fields merged in `summary_o`. Second, the asynchronous trap request can arrive together with a request that would otherwise be taken. The bench drives both together and expects `unsup_o` with no trap. When the asynchronous request is removed, it expects the interrupt to be taken at once as a fresh rising condition.

// File: rtl/irl_pkg.sv
package irl_pkg;

    localparam int unsigned IRL_WORD_W = 32;
    localparam int unsigned IRL_LVL_W  = $clog2(IRL_WORD_W);
    localparam int unsigned IRL_AST_W  = 4;

    typedef logic [IRL_WORD_W-1:0] irl_word_t;
    typedef logic [IRL_LVL_W-1:0]  irl_lvl_t;
    typedef logic [IRL_AST_W-1:0]  irl_ast_t;

    typedef struct packed {
        logic      trap;
        logic      take_seen;
        logic      unsup;
        irl_word_t summary;
        irl_lvl_t  id;
    } irl_state_t;

    function automatic irl_word_t irl_field_mask(input int lo, input int hi);
        irl_word_t m;
        m = '0;
        for (int b = 0; b < int'(IRL_WORD_W); b++) begin
            if (b >= lo && b <= hi) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irl_field_scan.sv
// Scans one request field in ascending order; the last set bit wins.
// OFFSET_MODE selects the level rule: 1 = relative to LO plus one,
// 0 = level equals the bit index.
module irl_field_scan
    import irl_pkg::*;
#(
    parameter int LO          = 4,
    parameter int HI          = 18,
    parameter bit OFFSET_MODE = 1'b1
) (
    input  irl_word_t req_i,
    output irl_word_t pend_o,
    output irl_lvl_t  lvl_o,
    output logic      any_o
);

    localparam irl_word_t FIELD_MASK = irl_field_mask(LO, HI);

    assign pend_o = req_i & FIELD_MASK;
    assign any_o  = |pend_o;

    generate
        if (OFFSET_MODE) begin : g_offset
            always_comb begin
                lvl_o = '0;
                for (int i = LO; i <= HI; i++) begin
                    if (pend_o[i]) lvl_o = irl_lvl_t'(i - LO + 1);
                end
            end
        end else begin : g_direct
            always_comb begin
                lvl_o = '0;
                for (int i = LO; i <= HI; i++) begin
                    if (pend_o[i]) lvl_o = irl_lvl_t'(i);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/irl_merge.sv
// Merges the two field results and decides whether to take an interrupt.
module irl_merge
    import irl_pkg::*;
(
    input  irl_word_t sw_pend_i,
    input  irl_lvl_t  sw_lvl_i,
    input  irl_word_t ext_pend_i,
    input  irl_lvl_t  ext_lvl_i,
    input  logic      ext_any_i,
    input  irl_lvl_t  cur_ipl_i,
    input  irl_ast_t  ast_req_i,
    output irl_word_t summary_o,
    output irl_lvl_t  lvl_o,
    output logic      ast_bad_o,
    output logic      take_o
);

    always_comb begin
        summary_o = sw_pend_i | ext_pend_i;
        // external field is scanned after software: it wins if present
        lvl_o     = ext_any_i ? ext_lvl_i : sw_lvl_i;
        ast_bad_o = |ast_req_i;
        take_o    = (lvl_o != '0) && (lvl_o > cur_ipl_i) && !ast_bad_o;
    end

endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
    import irl_pkg::*;
#(
    parameter int SW_LO  = 4,
    parameter int SW_HI  = 18,
    parameter int EXT_LO = 20,
    parameter int EXT_HI = 30
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IRL_WORD_W-1:0] sw_req_i,
    input  logic [IRL_WORD_W-1:0] ext_req_i,
    input  logic [IRL_LVL_W-1:0]  cur_ipl_i,
    input  logic [IRL_AST_W-1:0]  ast_req_i,
    output logic                  trap_o,
    output logic [IRL_WORD_W-1:0] summary_o,
    output logic [IRL_LVL_W-1:0]  int_id_o,
    output logic                  unsup_o
);

    irl_word_t  sw_pend, ext_pend, merged_sum;
    irl_lvl_t   sw_lvl, ext_lvl, merged_lvl;
    logic       sw_any, ext_any, ast_bad, take;
    irl_state_t st_d, st_q;

    irl_field_scan #(.LO(SW_LO), .HI(SW_HI), .OFFSET_MODE(1'b1)) u_sw_scan (
        .req_i  (sw_req_i),
        .pend_o (sw_pend),
        .lvl_o  (sw_lvl),
        .any_o  (sw_any)
    );

    irl_field_scan #(.LO(EXT_LO), .HI(EXT_HI), .OFFSET_MODE(1'b0)) u_ext_scan (
        .req_i  (ext_req_i),
        .pend_o (ext_pend),
        .lvl_o  (ext_lvl),
        .any_o  (ext_any)
    );

    irl_merge u_merge (
        .sw_pend_i  (sw_pend),
        .sw_lvl_i   (sw_lvl),
        .ext_pend_i (ext_pend),
        .ext_lvl_i  (ext_lvl),
        .ext_any_i  (ext_any),
        .cur_ipl_i  (cur_ipl_i),
        .ast_req_i  (ast_req_i),
        .summary_o  (merged_sum),
        .lvl_o      (merged_lvl),
        .ast_bad_o  (ast_bad),
        .take_o     (take)
    );

    always_comb begin
        st_d           = st_q;
        st_d.take_seen = take;
        st_d.unsup     = ast_bad;
        st_d.trap      = take && !st_q.take_seen;
        if (st_d.trap) begin
            st_d.summary = merged_sum;
            st_d.id      = merged_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trap_o    = st_q.trap;
    assign summary_o = st_q.summary;
    assign int_id_o  = st_q.id;
    assign unsup_o   = st_q.unsup;

    // software-side presence is carried for completeness of the scan interface
    logic sw_any_unused;
    assign sw_any_unused = sw_any;

endmodule

// File: rtl/irq_level_resolver_chk.sv
module irq_level_resolver_chk
    import irl_pkg::*;
#(
    parameter int EXT_LO = 20,
    parameter int EXT_HI = 30
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [IRL_LVL_W-1:0]  cur_ipl_i,
    input logic [IRL_AST_W-1:0]  ast_req_i,
    input logic                  trap_o,
    input logic [IRL_WORD_W-1:0] summary_o,
    input logic [IRL_LVL_W-1:0]  int_id_o,
    input logic                  unsup_o
);

    localparam irl_word_t EXT_MASK = irl_field_mask(EXT_LO, EXT_HI);

    assert_above_ipl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (int_id_o != '0) && (int_id_o > $past(cur_ipl_i)));

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> !trap_o);

    assert_status_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_o |-> ($stable(summary_o) && $stable(int_id_o)));

    assert_unsup_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|ast_req_i) |=> (unsup_o && !trap_o));

    assert_ext_in_summary_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && int_id_o >= IRL_LVL_W'(EXT_LO)) |-> summary_o[int_id_o]);

    assert_sw_win_no_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && int_id_o < IRL_LVL_W'(EXT_LO)) |-> ((summary_o & EXT_MASK) == '0));

endmodule

bind irq_level_resolver irq_level_resolver_chk #(.EXT_LO(EXT_LO), .EXT_HI(EXT_HI)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_ipl_i (cur_ipl_i),
    .ast_req_i (ast_req_i),
    .trap_o    (trap_o),
    .summary_o (summary_o),
    .int_id_o  (int_id_o),
    .unsup_o   (unsup_o)
);

// File: tb/irq_level_resolver_bench.sv
`timescale 1ns/1ps
module irq_level_resolver_bench;
    import irl_pkg::*;

    logic      clk = 1'b0;
    logic      rst_n = 1'b0;
    irl_word_t sw_req = '0, ext_req = '0;
    irl_lvl_t  cur_ipl = '0;
    irl_ast_t  ast_req = '0;
    logic      trap, unsup;
    irl_word_t summary;
    irl_lvl_t  int_id;

    always #2.5 clk = ~clk;

    irq_level_resolver u_irq_level_resolver (
        .clk(clk), .rst_n(rst_n), .sw_req_i(sw_req), .ext_req_i(ext_req),
        .cur_ipl_i(cur_ipl), .ast_req_i(ast_req), .trap_o(trap),
        .summary_o(summary), .int_id_o(int_id), .unsup_o(unsup)
    );

    typedef struct {
        logic      trap;
        logic      unsup;
        irl_word_t sum;
        irl_lvl_t  id;
        string     tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0, n_fail = 0;
    bit   finished = 0;

    // specification model state
    logic      m_prev = 0;
    irl_word_t m_sum = '0;
    irl_lvl_t  m_id = '0;

    task automatic step(input irl_word_t sw, input irl_word_t ext, input int ipl,
                        input int ast, input string tag);
        exp_t      e;
        irl_word_t s;
        int        lvl;
        logic      take;
        @(negedge clk);
        sw_req = sw; ext_req = ext; cur_ipl = irl_lvl_t'(ipl); ast_req = irl_ast_t'(ast);
        s = '0; lvl = 0;
        for (int i = 4; i <= 18; i++) if (sw[i]) begin s[i] = 1'b1; lvl = i - 3; end
        for (int i = 20; i <= 30; i++) if (ext[i]) begin s[i] = 1'b1; lvl = i; end
        take = (lvl != 0) && (lvl > ipl) && (ast == 0);
        e.trap = take && !m_prev;
        m_prev = take;
        if (e.trap) begin m_sum = s; m_id = irl_lvl_t'(lvl); end
        e.sum = m_sum; e.id = m_id; e.unsup = (ast != 0); e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step('0, '0, 0, 0, tag);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk); #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                n_checks++;
                if (trap !== e.trap || unsup !== e.unsup || summary !== e.sum || int_id !== e.id) begin
                    n_fail++;
                    $display("FAIL %s: got trap=%0b unsup=%0b sum=%h id=%0d, expected trap=%0b unsup=%0b sum=%h id=%0d",
                             e.tag, trap, unsup, summary, int_id, e.trap, e.unsup, e.sum, e.id);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin : watchdog
        #100000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #1;
        n_checks++;
        if (trap !== 0 || unsup !== 0 || summary !== '0 || int_id !== '0) begin
            n_fail++;
            $display("FAIL R9 reset: got trap=%0b unsup=%0b sum=%h id=%0d, expected all zero",
                     trap, unsup, summary, int_id);
        end
        @(negedge clk); rst_n = 1'b1;

        // R1 software mapping
        step(32'h1 << 4, '0, 0, 0, "R1 bit4 level1");   idle("R1 gap");
        step(32'h1 << 18, '0, 0, 0, "R1 bit18 level15"); idle("R1 gap");
        step((32'h1 << 5) | (32'h1 << 9), '0, 0, 0, "R1 highest sw wins"); idle("R1 gap");
        // R2 external mapping
        step('0, 32'h1 << 20, 0, 0, "R2 ext20");         idle("R2 gap");
        step('0, (32'h1 << 30) | (32'h1 << 22), 0, 0, "R2 ext30 wins"); idle("R2 gap");
        // R3 external outranks software
        step(32'h1 << 18, 32'h1 << 20, 0, 0, "R3 ext over sw"); idle("R3 gap");
        step((32'h1 << 4) | (32'h1 << 17), (32'h1 << 21) | (32'h1 << 25), 24, 0, "R3 mixed");
        idle("R3 gap");
        // R4 out-of-field bits ignored
        step(32'h8008_000F | (32'h1 << 7), '0, 0, 0, "R4 sw stray bits");  idle("R4 gap");
        step('0, 32'h8008_0001, 0, 0, "R4 ext stray bits no trap");
        step(32'h8008_000F, 32'h000F_FFFF, 0, 0, "R4 only stray bits no trap");
        // R5 strict compare
        step(32'h1 << 10, '0, 7, 0, "R5 equal level no trap"); idle("R5 gap");
        step(32'h1 << 10, '0, 6, 0, "R5 higher level trap");   idle("R5 gap");
        step('0, 32'h1 << 25, 25, 0, "R5 ext equal no trap");  idle("R5 gap");
        step('0, 32'h1 << 25, 31, 0, "R5 ipl above no trap");  idle("R5 gap");
        // R6 / R7 single pulse, status hold, re-arm
        step('0, 32'h1 << 23, 0, 0, "R6 first pulse");
        step('0, 32'h1 << 23, 0, 0, "R6 no repeat");
        step(32'h1 << 6, 32'h1 << 23, 0, 0, "R7 hold while asserted");
        idle("R6 drop");
        step(32'h1 << 6, '0, 0, 0, "R6 re-arm new capture");
        step(32'h1 << 6, '0, 9, 0, "R7 hold when not taken");
        idle("R7 gap");
        // R8 asynchronous trap request
        step('0, 32'h1 << 30, 0, 4'h1, "R8 unsup blocks trap");
        step('0, 32'h1 << 30, 0, 4'h8, "R8 unsup persists");
        step('0, 32'h1 << 30, 0, 0, "R8 released then taken");
        idle("R8 gap");
        step('0, '0, 0, 4'h2, "R8 unsup without request");
        idle("final");
        repeat (3) @(posedge clk);
        #2;
        finish_run();
    end

endmodule